// File: doc/BRIEF.md
# Text Word Serial Streamer with Request/Clock Handshake

This block sends 16-bit text words to a host, one bit at a time. Words enter through a valid/ready push port and wait in a small FIFO. The host raises a request line to ask for data. The block then shifts out whole words, most significant bit first. If the host lowers the request in the middle of a word, the block finishes that word before it goes idle, so the host never sees a partial word.

There are two clocking schemes, chosen by `mode_self`.

- **Host-clock mode** (`mode_self` = 0): the host drives the shift clock on `hck_i`. `host_idle_high` selects the level at which that clock rests between transfers.
- **Self-clock mode** (`mode_self` = 1): the block makes its own shift clock on `sck_o` by dividing the system clock by `2*DIV_HALF`. It adds a fixed start delay after the request rises and a fixed run-on after the request falls.

In both schemes, a *launch edge* is the clock edge on which the block puts the next data bit on `sdo_o`.

Push-port rules:
- A word is accepted on a clock where `wr_valid` and `wr_ready` are both high.
- `wr_ready` falls while the FIFO holds `FIFO_DEPTH` words.
- While `wr_ready` is low, the producer must hold `wr_valid` and `wr_data` until the word is accepted.

Usage rules:
- `mode_self` and `host_idle_high` are static settings. Change them only while the request is low and the output is idle.
- `req_i` is synchronous to `clk`.
- `hck_i` is asynchronous. Each of its levels must last at least four system clocks.

Top module: `ctx_tx`

## Requirements
- R1: `wr_ready` is high exactly when the FIFO holds fewer than `FIFO_DEPTH` words. A word is stored on each clock where `wr_valid` and `wr_ready` are both high, and words leave in the order they arrived.
- R2: Each word is sent as exactly 16 bits, bit 15 first and bit 0 last. Each launch edge puts the next bit on `sdo_o`, and the bit holds until the next launch edge.
- R3: In host-clock mode with `host_idle_high` = 0, the launch edge is a rising edge of `hck_i`. `hck_i` passes through a two-flop synchroniser and an edge detector, so `sdo_o` updates at the third rising `clk` edge after `hck_i` changes. The host samples the bit on the falling edge of `hck_i`.
- R4: In host-clock mode with `host_idle_high` = 1, the launch edge is a falling edge of `hck_i`, with the same three-clock latency as R3. The host samples on the rising edge.
- R5: A new word starts only on a launch edge at which `req_i` is high and the FIFO is not empty. The first bit of the word appears on that edge. Launch edges that occur while `req_i` is low leave `sdo_o` low and take nothing from the FIFO.
- R6: If `req_i` falls during a word, the remaining bits of that word are still sent. The launch edge after bit 0 drives `sdo_o` low and no further word starts.
- R7: `sck_o` is high after reset, during all of host-clock mode, and whenever self-clock mode is idle.
- R8: In self-clock mode, let the first rising `clk` edge that sees `req_i` high while idle be edge 0. The first falling edge of `sck_o` occurs at `clk` edge `START_PER*2*DIV_HALF + DIV_HALF`. After that, `sck_o` toggles every `DIV_HALF` clocks. If `req_i` drops during the start delay, the block returns to idle.
- R9: In self-clock mode, `sdo_o` changes only together with a falling edge of `sck_o`, so the host can sample on the rising edge.
- R10: In self-clock mode, once `req_i` is low and no word is in progress, `sck_o` keeps running for `STOP_PER` more periods after its next rising edge. It then parks high.
- R11: If a launch edge finds the FIFO empty, `sdo_o` drives low and no word is removed. A word pushed later is sent complete, exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Push request for a text word |
| wr_ready | output | 1 | FIFO can accept a word |
| wr_data | input | WORD_W | Text word to push |
| mode_self | input | 1 | 0: host supplies the shift clock; 1: block generates it |
| host_idle_high | input | 1 | Resting level of the host clock (host-clock mode only) |
| req_i | input | 1 | Host data request |
| hck_i | input | 1 | Host-supplied shift clock (asynchronous) |
| sck_o | output | 1 | Generated shift clock (held high when unused) |
| sdo_o | output | 1 | Serial data out |

## Verification
The hardest situation to reach is the request falling in the middle of a word while further words are queued. This must be followed by an exact count of run-on clock periods in self-clock mode. The bench reaches it by counting falling edges of `sck_o` after the request rises and dropping the request right after the 20th, which is four bits into the second word. It then expects 12 remaining bits, one ending edge and `STOP_PER` run-on periods before the clock parks high.

A second hard point is an empty FIFO under an active request. The bench drains the FIFO with host clocks still running, then pushes one word in the middle of the clock stream. That word must arrive whole, exactly once.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {
    GEN_IDLE,
    GEN_START,
    GEN_RUN,
    GEN_DRAIN
  } gen_state_t;
endpackage

// File: rtl/ctx_fifo.sv
module ctx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ctx_hclk_edge.sv
module ctx_hclk_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic idle_high,
  input  logic hck_i,
  output logic launch_o
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN-2:0], hck_i};
  end

  logic synced, prev;
  assign synced = chain[CHAIN-2];
  assign prev   = chain[CHAIN-1];

  always_comb begin
    if (idle_high) launch_o = enable && prev && !synced;
    else           launch_o = enable && !prev && synced;
  end
endmodule

// File: rtl/ctx_sck_gen.sv
module ctx_sck_gen
  import ctx_pkg::*;
#(
  parameter int DIV_HALF  = 4,
  parameter int START_PER = 32,
  parameter int STOP_PER  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic req_i,
  input  logic busy,
  output logic sck_o,
  output logic launch_o
);
  localparam int START_CLKS = START_PER * 2 * DIV_HALF;
  localparam int SW = $clog2(START_CLKS + 1);
  localparam int HW = $clog2(DIV_HALF + 1);
  localparam int PW = $clog2(STOP_PER + 1);

  gen_state_t    state;
  logic [SW-1:0] start_cnt;
  logic [HW-1:0] half_cnt;
  logic [PW-1:0] per_cnt;
  logic          toggle;

  assign toggle   = (state == GEN_RUN || state == GEN_DRAIN) &&
                    (half_cnt == HW'(DIV_HALF - 1));
  assign launch_o = toggle && sck_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= GEN_IDLE;
      start_cnt <= '0;
      half_cnt  <= '0;
      per_cnt   <= '0;
      sck_o     <= 1'b1;
    end else if (!enable) begin
      state <= GEN_IDLE;
      sck_o <= 1'b1;
    end else begin
      case (state)
        GEN_IDLE: begin
          sck_o <= 1'b1;
          if (req_i) begin
            state     <= GEN_START;
            start_cnt <= '0;
          end
        end
        GEN_START: begin
          if (!req_i) state <= GEN_IDLE;
          else if (start_cnt == SW'(START_CLKS - 1)) begin
            state    <= GEN_RUN;
            half_cnt <= '0;
          end else start_cnt <= start_cnt + 1'b1;
        end
        default: begin
          if (toggle) begin
            half_cnt <= '0;
            sck_o    <= !sck_o;
            if (!sck_o) begin
              if (state == GEN_RUN) begin
                if (!req_i && !busy) begin
                  state   <= GEN_DRAIN;
                  per_cnt <= '0;
                end
              end else if (req_i) state <= GEN_RUN;
              else if (per_cnt == PW'(STOP_PER - 1)) state <= GEN_IDLE;
              else per_cnt <= per_cnt + 1'b1;
            end
          end else half_cnt <= half_cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ctx_shifter.sv
module ctx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic         req_i,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_dout,
  output logic         pop,
  output logic         busy,
  output logic         sdo_o
);
  localparam int LW = $clog2(W);

  logic [W-1:0]  shreg;
  logic [LW-1:0] left;
  logic          mid_word;

  assign mid_word = busy && (left != '0);
  assign pop      = launch && !mid_word && req_i && !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      busy  <= 1'b0;
      sdo_o <= 1'b0;
    end else if (launch) begin
      if (mid_word) begin
        sdo_o <= shreg[W-1];
        shreg <= shreg << 1;
        left  <= left - 1'b1;
      end else if (pop) begin
        sdo_o <= fifo_dout[W-1];
        shreg <= fifo_dout << 1;
        left  <= LW'(W - 1);
        busy  <= 1'b1;
      end else begin
        sdo_o <= 1'b0;
        busy  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctx_tx.sv
module ctx_tx #(
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_HALF   = 4,
  parameter int START_PER  = 32,
  parameter int STOP_PER   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              mode_self,
  input  logic              host_idle_high,
  input  logic              req_i,
  input  logic              hck_i,
  output logic              sck_o,
  output logic              sdo_o
);
  logic              launch_h, launch_s, launch;
  logic              pop, busy, fifo_empty, fifo_full;
  logic [WORD_W-1:0] fifo_dout;

  assign wr_ready = !fifo_full;
  assign launch   = mode_self ? launch_s : launch_h;

  ctx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_valid && wr_ready), .din(wr_data),
    .pop(pop), .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty)
  );

  ctx_hclk_edge #(.SYNC_STAGES(2)) u_hedge (
    .clk(clk), .rst_n(rst_n), .enable(!mode_self), .idle_high(host_idle_high),
    .hck_i(hck_i), .launch_o(launch_h)
  );

  ctx_sck_gen #(.DIV_HALF(DIV_HALF), .START_PER(START_PER), .STOP_PER(STOP_PER)) u_gen (
    .clk(clk), .rst_n(rst_n), .enable(mode_self), .req_i(req_i), .busy(busy),
    .sck_o(sck_o), .launch_o(launch_s)
  );

  ctx_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .launch(launch), .req_i(req_i),
    .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .pop(pop), .busy(busy),
    .sdo_o(sdo_o)
  );
endmodule

// File: rtl/ctx_tx_chk.sv
module ctx_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_self,
  input logic req_i,
  input logic sck_o,
  input logic sdo_o,
  input logic wr_ready,
  input logic launch,
  input logic pop,
  input logic fifo_empty
);
  // R7: generated clock rests high whenever the host supplies the clock
  assert_sck_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_self |-> sck_o);

  // R2: serial data moves only on a launch edge
  assert_sdo_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(launch));

  // R9: in self-clock mode data moves together with a falling generated clock
  assert_fall_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_self && !$stable(sdo_o)) |-> $fell(sck_o));

  // R11: nothing is taken from an empty FIFO
  assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);

  // R5: a word starts only under an active request
  assert_start_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> req_i);

  // R1: a removal always leaves room for a push
  assert_ready_after_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> wr_ready);
endmodule

bind ctx_tx ctx_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_self(mode_self), .req_i(req_i),
  .sck_o(sck_o), .sdo_o(sdo_o), .wr_ready(wr_ready), .launch(launch),
  .pop(pop), .fifo_empty(fifo_empty)
);

// File: tb/ctx_tx_tb.sv
module ctx_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int DEPTH      = 4;
  localparam int DIV        = 4;
  localparam int START_PER  = 32;
  localparam int STOP_PER   = 32;
  localparam int START_CLKS = START_PER * 2 * DIV;
  localparam int H          = 6;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, mode_self = 1'b0, idle_hi = 1'b0, req = 1'b0, hck = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic wr_ready, sck_o, sdo_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctx_tx #(.WORD_W(W), .FIFO_DEPTH(DEPTH), .DIV_HALF(DIV), .START_PER(START_PER),
           .STOP_PER(STOP_PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .mode_self(mode_self), .host_idle_high(idle_hi),
    .req_i(req), .hck_i(hck), .sck_o(sck_o), .sdo_o(sdo_o)
  );

  int checks = 0, errors = 0;
  string tag = "R7";
  bit done = 1'b0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int q[$];
  bit m_sdo, m_busy, m_sck;
  int m_left;
  logic [W-1:0] m_sh;
  bit h1, h2, h3;
  int gs, gc, gh, gp;   // 0 idle, 1 start, 2 run, 3 drain

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_sdo = 0; m_busy = 0; m_sck = 1; m_left = 0; m_sh = '0;
      h1 = 0; h2 = 0; h3 = 0; gs = 0; gc = 0; gh = 0; gp = 0;
    end else begin
      bit lh, ls, launch, rdy, mid;
      int pre_sz;
      lh = !mode_self && (idle_hi ? (h3 && !h2) : (!h3 && h2));
      ls = 0;
      if (!mode_self) begin
        gs = 0; m_sck = 1;
      end else begin
        case (gs)
          0: begin m_sck = 1; if (req) begin gs = 1; gc = 0; end end
          1: begin
            if (!req) gs = 0;
            else if (gc == START_CLKS - 1) begin gs = 2; gh = 0; end
            else gc++;
          end
          default: begin
            if (gh == DIV - 1) begin
              gh = 0;
              if (m_sck) begin ls = 1; m_sck = 0; end
              else begin
                m_sck = 1;
                if (gs == 2) begin
                  if (!req && !m_busy) begin gs = 3; gp = 0; end
                end else if (req) gs = 2;
                else if (gp == STOP_PER - 1) gs = 0;
                else gp++;
              end
            end else gh++;
          end
        endcase
      end
      launch = mode_self ? ls : lh;
      pre_sz = q.size();
      rdy = pre_sz < DEPTH;
      if (launch) begin
        mid = m_busy && m_left != 0;
        if (mid) begin
          m_sdo = m_sh[W-1]; m_sh = m_sh << 1; m_left--;
        end else if (req && pre_sz > 0) begin
          m_sh = W'(q.pop_front());
          m_sdo = m_sh[W-1]; m_sh = m_sh << 1; m_left = W - 1; m_busy = 1;
        end else begin
          m_sdo = 0; m_busy = 0;
        end
      end
      if (wr_valid && rdy) q.push_back(int'(wr_data));
      h3 = h2; h2 = h1; h1 = hck;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sdo_o == m_sdo, tag, "sdo_o vs model", int'(sdo_o), int'(m_sdo));
      check(sck_o == m_sck, tag, "sck_o vs model", int'(sck_o), int'(m_sck));
      check(wr_ready == (q.size() < DEPTH), "R1", "wr_ready vs model",
            int'(wr_ready), int'(q.size() < DEPTH));
    end
  end

  int cyc_total = 0;
  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc_total, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic push_word(input logic [W-1:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic host_cycle(output logic b);
    hck = !idle_hi;
    repeat (H) @(negedge clk);
    b = sdo_o;
    hck = idle_hi;
    repeat (H) @(negedge clk);
  endtask

  task automatic host_word(input int nbits, output logic [W-1:0] w);
    logic b;
    w = '0;
    for (int i = 0; i < nbits; i++) begin
      host_cycle(b);
      w = {w[W-2:0], b};
    end
  endtask

  initial begin
    logic [W-1:0] w;
    logic b;
    int cyc, falls, quiet;
    bit prev;

    repeat (3) @(negedge clk);
    check(sdo_o == 1'b0, "R7", "reset sdo", int'(sdo_o), 0);
    check(sck_o == 1'b1, "R7", "reset sck", int'(sck_o), 1);
    check(wr_ready == 1'b1, "R1", "reset ready", int'(wr_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fill to capacity
    tag = "R1";
    push_word(16'hA5C3); push_word(16'h1234); push_word(16'h8001); push_word(16'h7FFE);
    check(wr_ready == 1'b0, "R1", "ready low when full", int'(wr_ready), 0);

    // R3 / R2: host clock idling low
    tag = "R3";
    req = 1'b1;
    host_word(16, w);
    check(w == 16'hA5C3, "R3", "word on rising launch, MSB first (R2)", int'(w), 16'hA5C3);
    check(wr_ready == 1'b1, "R1", "ready after pop", int'(wr_ready), 1);
    host_word(8, w);
    check(w[7:0] == 8'h12, "R2", "upper byte of second word", int'(w[7:0]), 8'h12);

    // R6: request withdrawn mid word
    tag = "R6";
    req = 1'b0;
    host_word(8, w);
    check(w[7:0] == 8'h34, "R6", "word finished after request drop", int'(w[7:0]), 8'h34);
    host_cycle(b);
    check(b == 1'b0, "R6", "idle low after word", int'(b), 0);
    host_cycle(b);
    check(b == 1'b0, "R5", "no start without request", int'(b), 0);

    // R4: host clock idling high
    tag = "R4";
    idle_hi = 1'b1; hck = 1'b1;
    repeat (8) @(negedge clk);
    host_cycle(b);
    check(b == 1'b0, "R5", "launch with request low", int'(b), 0);
    req = 1'b1;
    host_word(16, w);
    check(w == 16'h8001, "R4", "word on falling launch", int'(w), 16'h8001);
    host_word(16, w);
    check(w == 16'h7FFE, "R4", "second word idle high", int'(w), 16'h7FFE);

    // R11: empty FIFO under active request
    tag = "R11";
    host_word(3, w);
    check(w[2:0] == 3'b000, "R11", "low while empty", int'(w[2:0]), 0);
    push_word(16'h0F0F);
    host_word(16, w);
    check(w == 16'h0F0F, "R11", "late word sent whole", int'(w), 16'h0F0F);
    host_word(2, w);
    check(w[1:0] == 2'b00, "R11", "no duplicate word", int'(w[1:0]), 0);
    req = 1'b0;
    host_cycle(b);
    idle_hi = 1'b0; hck = 1'b0;
    repeat (8) @(negedge clk);

    // R8 / R9 / R10: self-generated clock
    tag = "R8";
    mode_self = 1'b1;
    @(negedge clk);
    push_word(16'hA5C3); push_word(16'h5A5A); push_word(16'hFFFF);
    check(sck_o == 1'b1, "R7", "self idle sck high", int'(sck_o), 1);
    req = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (sck_o);
    check(cyc == START_CLKS + DIV + 1, "R8", "start delay cycles", cyc, START_CLKS + DIV + 1);
    tag = "R9";
    falls = 1; prev = 1'b0;
    while (falls < 20) begin
      @(negedge clk);
      if (!sck_o && prev) falls++;
      prev = sck_o;
    end
    tag = "R10";
    req = 1'b0;
    falls = 0; quiet = 0;
    while (quiet < 4 * DIV) begin
      @(negedge clk);
      if (!sck_o && prev) falls++;
      quiet = sck_o ? quiet + 1 : 0;
      prev = sck_o;
    end
    check(falls == 12 + 1 + STOP_PER, "R10", "falls after request drop", falls, 12 + 1 + STOP_PER);
    check(sck_o == 1'b1 && sdo_o == 1'b0, "R10", "parked high, data low",
          int'({sck_o, sdo_o}), 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule